// File: doc/BRIEF.md
# Receive Buffer Handshake and Interrupt Logic

This block holds the receive-side status and the interrupt logic for a message controller with two receive buffers. A background buffer takes in each message as it completes. Once the CPU has released the previous message, the block hands the background message to a foreground buffer that the CPU reads. The block does not store message contents. It pulses a load strobe, and the storage logic copies the background slot into the foreground slot on that edge.

The block keeps an 8-bit sticky flag register and an 8-bit interrupt enable register. Both registers share one bit layout and are reached through a simple register port. To clear a flag, the CPU writes 1 to its bit. Clearing the receive-full flag is the handshake that returns the foreground buffer. The block drives three registered interrupt lines:

- a receive interrupt;
- an error interrupt, which collects the warning, error, bus-off and overrun flags;
- a wake-up interrupt.

A soft-reset level keeps all flags cleared and empties the background slot.

Top module: `rxh_status_top`

## Requirements
- R1: After rst_n is released, the flag register, the enable register and all three interrupt outputs read 0.
- R2: A msg_done strobe into an empty background slot marks that slot occupied on the next edge. While the slot is occupied and the receive-full flag (bit 0) is clear, fg_load is high. On that edge bit 0 is set.
- R3: While bit 0 is set, fg_load stays low and a message in the background slot is not moved.
- R4: Writing the flag register clears each flag whose written bit is 1. Flags whose written bit is 0 keep their value. A set event arriving on the same edge as a clear wins.
- R5: After the CPU clears bit 0 while the background slot is occupied, fg_load is high in the next cycle, and bit 0 is set again on the following edge.
- R6: A msg_done strobe that arrives while the background slot is occupied and bit 0 is set sets the overrun flag (bit 1) and discards the new message.
- R7: The event strobes set sticky flags:
  - evt[5] sets bit 7 (wake-up);
  - evt[4] sets bit 6 (receiver warning);
  - evt[3] sets bit 5 (transmitter warning);
  - evt[2] sets bit 4 (receiver error);
  - evt[1] sets bit 3 (transmitter error);
  - evt[0] sets bit 2 (bus-off).
- R8: The enable register is written and read at EN_ADDR, with the same bit layout as the flags. The flag register reads at FLAG_ADDR. Any other address reads 0.
- R9: irq_rx equals, one cycle later, flag bit 0 AND enable bit 0.
- R10: irq_err equals, one cycle later, the OR over bits 6 down to 1 of flag AND enable.
- R11: irq_wake equals, one cycle later, flag bit 7 AND enable bit 7.
- R12: While soft_rst is high:
  - all flags read 0;
  - events, msg_done and flag writes are ignored;
  - the background slot is emptied;
  - the enable register keeps its value and can still be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Soft-reset level; holds the flags clear |
| msg_done | input | 1 | Strobe: a correctly received message has reached the background slot |
| evt | input | 6 | Status event strobes for flag bits 7..2 |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| fg_load | output | 1 | Background-to-foreground move on this edge |
| irq_rx | output | 1 | Registered receive interrupt |
| irq_err | output | 1 | Registered error interrupt |
| irq_wake | output | 1 | Registered wake-up interrupt |

## Verification
The bench builds the block with its defaults:

- ADDR_W of 4, with the flag register at 4 and the enables at 5;
- an error mask of bits 6..1;
- set-over-clear priority.

These defaults make every address reachable, including the unmapped ones that must read 0. They also let random traffic hit the exact edge where a write-1 clear meets a set event. The error mask puts the overrun flag and all five warning and error flags onto the error line, so every contributor to irq_err is exercised against the bench model.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
   localparam int FLG_W = 8;
   localparam int EVT_W = 6;
   localparam int EVT_LO = 2;
   localparam int BIT_RXF  = 0;
   localparam int BIT_OVR  = 1;
   localparam int BIT_WAKE = 7;
   typedef logic [FLG_W-1:0] reg8_t;
endpackage

// File: rtl/rxh_flag_cell.sv
module rxh_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_pri
         always_comb begin
            if (set_i)      nxt = 1'b1;
            else if (clr_i) nxt = 1'b0;
            else            nxt = q;
         end
      end else begin : g_clr_pri
         always_comb begin
            if (clr_i)      nxt = 1'b0;
            else if (set_i) nxt = 1'b1;
            else            nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (hold) q <= 1'b0;
      else           q <= nxt;
   end
endmodule

// File: rtl/rxh_buf_ctrl.sv
module rxh_buf_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic msg_done,
   input  logic rxf_q,
   output logic move_o,
   output logic ovr_o,
   output logic bg_full_o
);
   logic bg_q;

   // Move only when the foreground has been handed back.
   assign move_o    = bg_q & ~rxf_q & ~hold;
   // Both buffers occupied: the arriving message is dropped.
   assign ovr_o     = msg_done & bg_q & ~move_o & ~hold;
   assign bg_full_o = bg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bg_q <= 1'b0;
      else if (hold) bg_q <= 1'b0;
      else           bg_q <= msg_done | (bg_q & ~move_o);
   end
endmodule

// File: rtl/rxh_irq_gen.sv
module rxh_irq_gen
   import rxh_pkg::*;
#(
   parameter logic [FLG_W-1:0] ERR_MASK = 8'h7E
) (
   input  logic  clk,
   input  logic  rst_n,
   input  reg8_t flags,
   input  reg8_t en,
   output logic  irq_rx,
   output logic  irq_err,
   output logic  irq_wake
);
   reg8_t live;
   logic [FLG_W-1:0] err_terms;

   assign live = flags & en;

   genvar gi;
   generate
      for (gi = 0; gi < FLG_W; gi++) begin : g_err
         if (ERR_MASK[gi]) begin : g_on
            assign err_terms[gi] = live[gi];
         end else begin : g_off
            assign err_terms[gi] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_rx   <= 1'b0;
         irq_err  <= 1'b0;
         irq_wake <= 1'b0;
      end else begin
         irq_rx   <= live[BIT_RXF];
         irq_err  <= |err_terms;
         irq_wake <= live[BIT_WAKE];
      end
   end
endmodule

// File: rtl/rxh_status_top.sv
module rxh_status_top
   import rxh_pkg::*;
#(
   parameter int unsigned      ADDR_W    = 4,
   parameter int unsigned      FLAG_ADDR = 4,
   parameter int unsigned      EN_ADDR   = 5,
   parameter logic [FLG_W-1:0] ERR_MASK  = 8'h7E,
   parameter bit               SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              msg_done,
   input  logic [EVT_W-1:0]  evt,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [FLG_W-1:0]  cpu_wdata,
   output logic [FLG_W-1:0]  cpu_rdata,
   output logic              fg_load,
   output logic              irq_rx,
   output logic              irq_err,
   output logic              irq_wake
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

   generate
      if (FLAG_ADDR == EN_ADDR) begin : g_bad_map
         $error("flag and enable registers share an address");
      end
      if (FLAG_ADDR >= ADDR_SPAN || EN_ADDR >= ADDR_SPAN) begin : g_bad_span
         $error("register address outside ADDR_W range");
      end
      if (ERR_MASK[BIT_RXF] || ERR_MASK[BIT_WAKE]) begin : g_bad_mask
         $error("receive-full and wake-up bits cannot feed the error line");
      end
   endgenerate

   reg8_t flag_q;
   reg8_t en_q;
   reg8_t set_v;
   reg8_t clr_v;
   logic  move;
   logic  ovr;
   logic  bg_full_q;
   logic  wr_flag;
   logic  wr_en;

   assign wr_flag = cpu_wr && (cpu_addr == A_FLAG);
   assign wr_en   = cpu_wr && (cpu_addr == A_EN);

   rxh_buf_ctrl u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (soft_rst),
      .msg_done  (msg_done),
      .rxf_q     (flag_q[BIT_RXF]),
      .move_o    (move),
      .ovr_o     (ovr),
      .bg_full_o (bg_full_q)
   );

   always_comb begin
      set_v = '0;
      set_v[BIT_RXF] = move;
      set_v[BIT_OVR] = ovr;
      set_v[FLG_W-1:EVT_LO] = evt;
      clr_v = wr_flag ? cpu_wdata : '0;
   end

   genvar gb;
   generate
      for (gb = 0; gb < FLG_W; gb++) begin : g_flag
         rxh_flag_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (soft_rst),
            .set_i (set_v[gb]),
            .clr_i (clr_v[gb]),
            .q     (flag_q[gb])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= cpu_wdata;
   end

   always_comb begin
      if (cpu_addr == A_FLAG)    cpu_rdata = flag_q;
      else if (cpu_addr == A_EN) cpu_rdata = en_q;
      else                       cpu_rdata = '0;
   end

   assign fg_load = move;

   rxh_irq_gen #(.ERR_MASK(ERR_MASK)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flag_q),
      .en       (en_q),
      .irq_rx   (irq_rx),
      .irq_err  (irq_err),
      .irq_wake (irq_wake)
   );
endmodule

// File: rtl/rxh_checker.sv
module rxh_checker
   import rxh_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned FLAG_ADDR = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              msg_done,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [FLG_W-1:0]  cpu_wdata,
   input logic              fg_load,
   input logic              irq_rx,
   input logic              irq_wake,
   input logic [FLG_W-1:0]  flag_q,
   input logic [FLG_W-1:0]  en_q,
   input logic              bg_full_q
);
   a_r3_no_load_while_full: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[BIT_RXF] |-> !fg_load);

   a_r2_load_sets_rxf: assert property (@(posedge clk) disable iff (!rst_n)
      fg_load |=> flag_q[BIT_RXF]);

   a_r5_slot_refills_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (fg_load && !msg_done) |=> !bg_full_q);

   a_r6_overrun_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_done && bg_full_q && flag_q[BIT_RXF] && !soft_rst) |=> flag_q[BIT_OVR]);

   a_r4_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == ADDR_W'(FLAG_ADDR) && !cpu_wdata[BIT_WAKE]
       && flag_q[BIT_WAKE] && !soft_rst) |=> flag_q[BIT_WAKE]);

   a_r12_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (flag_q == '0) && !bg_full_q);

   a_r9_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_rx == $past(flag_q[BIT_RXF] & en_q[BIT_RXF]));

   a_r11_wake_line: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_wake == $past(flag_q[BIT_WAKE] & en_q[BIT_WAKE]));
endmodule

bind rxh_status_top rxh_checker #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .msg_done  (msg_done),
   .cpu_wr    (cpu_wr),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .fg_load   (fg_load),
   .irq_rx    (irq_rx),
   .irq_wake  (irq_wake),
   .flag_q    (flag_q),
   .en_q      (en_q),
   .bg_full_q (bg_full_q)
);

// File: tb/tb_rxh_status_top.sv
`timescale 1ns/1ps
module tb_rxh_status_top;
   localparam int AW = 4;
   localparam logic [AW-1:0] FA = 4'd4;
   localparam logic [AW-1:0] EA = 4'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          msg_done = 1'b0;
   logic [5:0]    evt = '0;
   logic          cpu_wr = 1'b0;
   logic [AW-1:0] cpu_addr = FA;
   logic [7:0]    cpu_wdata = '0;
   logic [7:0]    cpu_rdata;
   logic          fg_load, irq_rx, irq_err, irq_wake;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   // bench model state
   logic [7:0] m_fl = '0, m_en = '0;
   logic       m_bg = 1'b0, m_irx = 1'b0, m_ierr = 1'b0, m_iwk = 1'b0;

   always #10 clk = ~clk;

   rxh_status_top dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .msg_done(msg_done),
      .evt(evt), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .fg_load(fg_load), .irq_rx(irq_rx),
      .irq_err(irq_err), .irq_wake(irq_wake)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [AW-1:0] a);
      if (a == FA)      return m_fl;
      else if (a == EA) return m_en;
      else              return 8'h00;
   endfunction

   function automatic logic exp_move();
      return m_bg & ~m_fl[0] & ~soft_rst;
   endfunction

   task automatic model_step();
      logic [7:0] nf;
      logic mv;
      mv = exp_move();
      m_irx  = m_fl[0] & m_en[0];
      m_ierr = |(m_fl & m_en & 8'h7E);
      m_iwk  = m_fl[7] & m_en[7];
      if (cpu_wr && cpu_addr == EA) m_en = cpu_wdata;
      if (soft_rst) begin
         m_fl = '0;
         m_bg = 1'b0;
      end else begin
         nf = m_fl;
         if (cpu_wr && cpu_addr == FA) nf = nf & ~cpu_wdata;
         nf[7:2] = nf[7:2] | evt;
         if (mv) nf[0] = 1'b1;
         if (msg_done && m_bg && !mv) nf[1] = 1'b1;
         m_fl = nf;
         m_bg = msg_done | (m_bg & ~mv);
      end
   endtask

   // compare all outputs with the model, advance one clock
   task automatic cyc();
      #1;
      chk("R2 fg_load", {7'd0, fg_load}, {7'd0, exp_move()});
      chk("R8 rdata", cpu_rdata, exp_rd(cpu_addr));
      chk("R9 irq_rx", {7'd0, irq_rx}, {7'd0, m_irx});
      chk("R10 irq_err", {7'd0, irq_err}, {7'd0, m_ierr});
      chk("R11 irq_wake", {7'd0, irq_wake}, {7'd0, m_iwk});
      model_step();
      @(negedge clk);
   endtask

   task automatic idle();
      msg_done = 1'b0; evt = '0; cpu_wr = 1'b0; cpu_wdata = '0;
   endtask

   task automatic rd_flags(input string req, input logic [7:0] exp);
      cpu_addr = FA; #1;
      chk(req, cpu_rdata, exp);
   endtask

   initial begin
      #(200000 * 20);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cpu_addr = FA; #1; chk("R1 flags", cpu_rdata, 8'h00);
      cpu_addr = EA; #1; chk("R1 enables", cpu_rdata, 8'h00);
      chk("R1 irqs", {5'd0, irq_rx, irq_err, irq_wake}, 8'h00);
      cpu_addr = 4'd9; #1; chk("R8 unmapped", cpu_rdata, 8'h00);

      // R8 enable write
      cpu_wr = 1'b1; cpu_addr = EA; cpu_wdata = 8'hFF; cyc(); idle();
      cpu_addr = EA; #1; chk("R8 enable readback", cpu_rdata, 8'hFF);

      // R2 first message
      msg_done = 1'b1; cyc(); idle();
      #1; chk("R2 load strobe", {7'd0, fg_load}, 8'h01);
      cyc();
      rd_flags("R2 rxf set", 8'h01);
      // R3 second message stays in background
      msg_done = 1'b1; cyc(); idle(); cyc(); cyc();
      #1; chk("R3 no load", {7'd0, fg_load}, 8'h00);
      rd_flags("R3 no overrun", 8'h01);
      // R6 third message overruns
      msg_done = 1'b1; cyc(); idle();
      rd_flags("R6 overrun flag", 8'h03);
      cyc();
      #1; chk("R10 err line", {7'd0, irq_err}, 8'h01);
      // R4 write 0 then write-1 clear
      cpu_wr = 1'b1; cpu_addr = FA; cpu_wdata = 8'h00; cyc(); idle();
      rd_flags("R4 write zero keeps", 8'h03);
      cpu_wr = 1'b1; cpu_addr = FA; cpu_wdata = 8'h02; cyc(); idle();
      rd_flags("R4 clear overrun only", 8'h01);
      // R5 release and refill
      cpu_wr = 1'b1; cpu_addr = FA; cpu_wdata = 8'h01; cyc(); idle();
      rd_flags("R5 released", 8'h00);
      chk("R5 move next", {7'd0, fg_load}, 8'h01);
      cyc();
      rd_flags("R5 rxf again", 8'h01);
      cpu_wr = 1'b1; cpu_addr = FA; cpu_wdata = 8'h01; cyc(); idle();
      #1; chk("R6 dropped message not moved", {7'd0, fg_load}, 8'h00);
      // R7 events
      evt = 6'b100001; cyc(); idle();
      rd_flags("R7 wake and busoff", 8'h84);
      evt = 6'b011110; cyc(); idle();
      rd_flags("R7 other events", 8'hFC);
      cyc();
      #1; chk("R11 wake line", {7'd0, irq_wake}, 8'h01);
      // R4 set beats clear
      evt = 6'b000010; cpu_wr = 1'b1; cpu_addr = FA; cpu_wdata = 8'h08; cyc(); idle();
      rd_flags("R4 set wins", 8'hFC);
      // R12 soft reset
      soft_rst = 1'b1; msg_done = 1'b1; evt = 6'h3F; cyc(); idle();
      rd_flags("R12 flags held", 8'h00);
      cpu_wr = 1'b1; cpu_addr = EA; cpu_wdata = 8'hA5; cyc(); idle();
      cpu_addr = EA; #1; chk("R12 enables writable", cpu_rdata, 8'hA5);
      soft_rst = 1'b0; cyc();
      #1; chk("R12 slot emptied", {7'd0, fg_load}, 8'h00);
      rd_flags("R12 after release", 8'h00);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom;
         soft_rst  = (r[7:0] < 8'd4);
         msg_done  = r[8] & r[9];
         evt       = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'd0;
         cpu_wr    = ($urandom_range(0, 5) == 0);
         cpu_addr  = ($urandom_range(0, 7) == 0) ? AW'($urandom) :
                     (r[10] ? FA : EA);
         cpu_wdata = 8'($urandom);
         cyc();
      end
      idle();
      soft_rst = 1'b0;
      cyc();

      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule